// File: doc/BRIEF.md
# Mode-Aware Five-Pin GPIO Port

This block is a five-pin general-purpose I/O port that sits behind a small register bus. It owns two registers. The pin-direction register can be written but not read. The output-data register can be both written and read. From these registers the block drives a pad output value and an output enable for each pin.

Two things on top of plain I/O set it apart. First, the reset value of one direction bit depends on the chip's operating mode, and only some reset and standby events clear the registers. Second, in the expanded modes the direction bits themselves hand pins 0 to 3 over to the chip-select strobes coming from the bus controller. When a DRAM interface is configured, pin 4 carries the column strobe.

During software standby the port can either hold the bus-control pins at their last driven level or release them to high impedance. A select input chooses between the two. The bus controller, the pad cells and input synchronisation lie outside this block.

Top module: `gpio_mode_port`

## Requirements
- R1: On a clock edge with `rst_n` low or `hw_stby_i` high, data bits 4:0 become 0. Direction bits 3:0 become 0. Direction bit 4 becomes 1 when `mode_i` is 0 or 1 (modes 4 and 5) and 0 when `mode_i` is 2 or 3 (modes 6 and 7).
- R2: On a clock edge with `wr_i` high, a write lands in the direction register when `addr_i`=0 and in the data register when `addr_i`=1, using `wdata_i[4:0]`. Bits 7:5 of `wdata_i` have no effect.
- R3: A read with `addr_i`=0 (direction register) returns the fixed pattern 8'hFF, whatever the register holds.
- R4: A read with `addr_i`=1 returns 0 in bits 7:5. Each bit 4:0 returns the data bit for a pin whose direction bit is 1, and `pad_in_i` for a pin whose direction bit is 0.
- R5: In mode 7 (`mode_i`=3), each pin is plain I/O: `pad_oe_o` equals the direction bits, and enabled pins drive the data bits.
- R6: In modes 4 to 6 (`mode_i`=0,1,2), pin i (0..3) with direction bit 1 is enabled and drives `cs_n_i[i]`. With direction bit 0 it is an input (enable 0).
- R7: In modes 4 to 6 with `dram_en_i` high, pin 4 is enabled and drives `cas_n_i`. Otherwise pin 4 is plain I/O under its direction bit.
- R8: While `man_rst_i` is high, both registers keep their values and bus writes are ignored.
- R9: While `sw_stby_i` is high, both registers keep their values and writes are ignored. Pins in plain I/O use go on driving as before.
- R10: In software standby with `keep_out_i` high, every bus-control pin (a chip-select or column-strobe pin from R6/R7) stays enabled. It holds the level it drove in the last cycle before standby began.
- R11: In software standby with `keep_out_i` low, every bus-control pin is released (enable 0).
- R12: While `hw_stby_i` is high, all five output enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hw_stby_i | input | 1 | Hardware standby: pins released, registers reinitialised |
| man_rst_i | input | 1 | Manual reset: registers retained, writes ignored |
| sw_stby_i | input | 1 | Software standby |
| keep_out_i | input | 1 | In software standby, 1 holds bus-control pins, 0 releases them |
| mode_i | input | 2 | Operating mode: 0=mode 4, 1=mode 5, 2=mode 6, 3=mode 7 |
| dram_en_i | input | 1 | DRAM interface selected |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 direction, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the register selected by `addr_i` |
| cs_n_i | input | 4 | Chip-select strobes from the bus controller |
| cas_n_i | input | 1 | Column strobe from the bus controller |
| pad_in_i | input | 5 | Pad input levels |
| pad_out_o | output | 5 | Pad output values |
| pad_oe_o | output | 5 | Pad output enables |

## Verification
The pin multiplexer is tried first with directed patterns. Alternating chip-select levels under a mixed direction mask show which pins follow the strobe bus and which stay inputs. A DRAM-enabled run in mode 6 and then in mode 7 shows that the column strobe takes pin 4 only in the expanded modes. A chip-select change during software standby separates the hold behaviour from pass-through.

Reset is run once per mode. This shows that only the mode picks the reset value of bit 4. Writes carrying ones in the reserved bits show they are dropped.

A long random run then mixes modes, direction masks, writes, pad levels and the three reset/standby events against a bench model. This catches orderings where a write, a standby entry and a strobe change fall on neighbouring cycles.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and mode encoding for the mode-aware GPIO port.
// Assumes the operating mode is encoded on two bits, with the value order
// fixed by the boot logic that drives mode_i.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        OPM_4 = 2'd0,   // expanded, boot direction of strobe pin = output
        OPM_5 = 2'd1,   // expanded, boot direction of strobe pin = output
        OPM_6 = 2'd2,   // expanded, strobe pin boots as input
        OPM_7 = 2'd3    // single-chip, all pins plain I/O
    } opmode_e;

    localparam logic ADDR_DIR = 1'b0;
    localparam logic ADDR_DAT = 1'b1;

endpackage

// File: rtl/gpio_port_regs.sv
// Module: direction and data registers with the bus read path.
// Assumes writes are single-cycle strobes sampled on the rising edge, and
// that the boot direction value is already resolved from the mode.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int          NUM_PINS     = 5,
    parameter int          BUS_W        = 8,
    parameter logic [7:0]  DIR_READ_PAT = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_stby_i,
    input  logic                man_rst_i,
    input  logic                sw_stby_i,
    input  logic [NUM_PINS-1:0] boot_dir_i,
    input  logic                wr_i,
    input  logic                addr_i,
    input  logic [BUS_W-1:0]    wdata_i,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] dat_q,
    output logic [BUS_W-1:0]    rdata_o
);

    localparam int RSV_W = BUS_W - NUM_PINS;

    logic                wr_ok;
    logic [NUM_PINS-1:0] rd_mix;
    logic                unused_rsv;

    // Writes are accepted only when neither manual reset nor software standby is active.
    assign wr_ok      = wr_i && !man_rst_i && !sw_stby_i;
    assign unused_rsv = ^wdata_i[BUS_W-1:NUM_PINS];

    // Register update: power-on reset or hardware standby reinitialise; otherwise accept writes.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby_i) begin
            dir_q <= boot_dir_i;
            dat_q <= '0;
        end else if (wr_ok) begin
            if (addr_i == ADDR_DIR) begin
                dir_q <= wdata_i[NUM_PINS-1:0];
            end else begin
                dat_q <= wdata_i[NUM_PINS-1:0];
            end
        end
    end

    // Read path: output pins show latched data, input pins show the pad level.
    always_comb begin
        rd_mix = (dat_q & dir_q) | (pad_in_i & ~dir_q);
        if (addr_i == ADDR_DIR) begin
            rdata_o = DIR_READ_PAT[BUS_W-1:0];
        end else begin
            rdata_o = {{RSV_W{1'b0}}, rd_mix};
        end
    end

endmodule

// File: rtl/gpio_pin_mux.sv
// Module: per-pin function selection, standby hold register and enable gating.
// Assumes chip-select pins occupy the low NUM_CS indices and the column
// strobe uses index STROBE_PIN; any other pin is plain I/O.
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS   = 5,
    parameter int NUM_CS     = 4,
    parameter int STROBE_PIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                dram_en_i,
    input  logic                hw_stby_i,
    input  logic                sw_stby_i,
    input  logic                keep_out_i,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] dat_q,
    input  logic [NUM_CS-1:0]   cs_n_i,
    input  logic                cas_n_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o
);

    logic                expanded;
    logic [NUM_PINS-1:0] bus_sel;
    logic [NUM_PINS-1:0] bus_val;
    logic [NUM_PINS-1:0] live_out;
    logic [NUM_PINS-1:0] live_oe;
    logic [NUM_PINS-1:0] hold_q;
    logic [NUM_PINS-1:0] hold_sel;

    assign expanded = (mode_i != OPM_7);

    // Per-pin variant: chip-select, column strobe or plain I/O.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i < NUM_CS) begin : g_cs
            assign bus_sel[i] = expanded && dir_q[i];
            assign bus_val[i] = cs_n_i[i];
        end else if (i == STROBE_PIN) begin : g_cas
            assign bus_sel[i] = expanded && dram_en_i;
            assign bus_val[i] = cas_n_i;
        end else begin : g_plain
            assign bus_sel[i] = 1'b0;
            assign bus_val[i] = 1'b1;
        end
    end

    // Normal-operation pin value and enable.
    assign live_out = (bus_sel & bus_val) | (~bus_sel & dat_q);
    assign live_oe  = bus_sel | dir_q;

    // Hold register: tracks the live pin value until software standby freezes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '1;
        end else if (!sw_stby_i) begin
            hold_q <= live_out;
        end
    end

    // Standby substitution of bus-control pins.
    assign hold_sel  = {NUM_PINS{sw_stby_i}} & bus_sel;
    assign pad_out_o = (hold_sel & hold_q) | (~hold_sel & live_out);

    // Enable gating: hardware standby releases all, software standby may release bus pins.
    always_comb begin
        if (hw_stby_i) begin
            pad_oe_o = '0;
        end else if (sw_stby_i && !keep_out_i) begin
            pad_oe_o = live_oe & ~bus_sel;
        end else begin
            pad_oe_o = live_oe;
        end
    end

endmodule

// File: rtl/gpio_mode_port.sv
// Module: top of the mode-aware GPIO port.
// Assumes mode_i and dram_en_i are quasi-static configuration and that the
// bus controller supplies active-low strobes on cs_n_i and cas_n_i.
module gpio_mode_port
    import gpio_port_pkg::*;
#(
    parameter int          NUM_PINS     = 5,
    parameter int          NUM_CS       = 4,
    parameter int          BUS_W        = 8,
    parameter logic [7:0]  DIR_READ_PAT = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_stby_i,
    input  logic                man_rst_i,
    input  logic                sw_stby_i,
    input  logic                keep_out_i,
    input  logic [1:0]          mode_i,
    input  logic                dram_en_i,
    input  logic                wr_i,
    input  logic                addr_i,
    input  logic [BUS_W-1:0]    wdata_i,
    output logic [BUS_W-1:0]    rdata_o,
    input  logic [NUM_CS-1:0]   cs_n_i,
    input  logic                cas_n_i,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o
);

    localparam int STROBE_PIN = NUM_CS;

    logic [NUM_PINS-1:0] boot_dir;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] dat_q;

    // Boot direction: only the strobe pin depends on the mode.
    always_comb begin
        boot_dir             = '0;
        boot_dir[STROBE_PIN] = (mode_i == OPM_4) || (mode_i == OPM_5);
    end

    gpio_port_regs #(
        .NUM_PINS     (NUM_PINS),
        .BUS_W        (BUS_W),
        .DIR_READ_PAT (DIR_READ_PAT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_stby_i  (hw_stby_i),
        .man_rst_i  (man_rst_i),
        .sw_stby_i  (sw_stby_i),
        .boot_dir_i (boot_dir),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .pad_in_i   (pad_in_i),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .rdata_o    (rdata_o)
    );

    gpio_pin_mux #(
        .NUM_PINS   (NUM_PINS),
        .NUM_CS     (NUM_CS),
        .STROBE_PIN (STROBE_PIN)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .dram_en_i  (dram_en_i),
        .hw_stby_i  (hw_stby_i),
        .sw_stby_i  (sw_stby_i),
        .keep_out_i (keep_out_i),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .cs_n_i     (cs_n_i),
        .cas_n_i    (cas_n_i),
        .pad_out_o  (pad_out_o),
        .pad_oe_o   (pad_oe_o)
    );

endmodule

// File: rtl/gpio_mode_port_chk.sv
// Module: assertion checker for gpio_mode_port, attached by bind.
// Assumes default parameters of the top module.
module gpio_mode_port_chk #(
    parameter int         NUM_PINS     = 5,
    parameter int         NUM_CS       = 4,
    parameter int         BUS_W        = 8,
    parameter logic [7:0] DIR_READ_PAT = 8'hFF
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hw_stby_i,
    input logic                man_rst_i,
    input logic                sw_stby_i,
    input logic                keep_out_i,
    input logic [1:0]          mode_i,
    input logic                dram_en_i,
    input logic                addr_i,
    input logic [BUS_W-1:0]    rdata_o,
    input logic [NUM_CS-1:0]   cs_n_i,
    input logic                cas_n_i,
    input logic [NUM_PINS-1:0] pad_out_o,
    input logic [NUM_PINS-1:0] pad_oe_o,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] dat_q
);

    localparam int SP = NUM_CS;

    p_hw_hiz_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby_i |-> (pad_oe_o == '0));

    p_dir_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 1'b0) |-> (rdata_o == DIR_READ_PAT[BUS_W-1:0]));

    p_man_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !hw_stby_i && man_rst_i) |=> (dir_q == $past(dir_q) && dat_q == $past(dat_q)));

    p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !hw_stby_i && sw_stby_i) |=> (dir_q == $past(dir_q) && dat_q == $past(dat_q)));

    p_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && !hw_stby_i) |->
            (pad_oe_o == dir_q && ((pad_out_o ^ dat_q) & dir_q) == '0));

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_chk
        p_cs_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i != 2'd3 && dir_q[g] && !sw_stby_i && !hw_stby_i) |->
                (pad_oe_o[g] && pad_out_o[g] == cs_n_i[g]));
    end

    p_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd3 && dram_en_i && !sw_stby_i && !hw_stby_i) |->
            (pad_oe_o[SP] && pad_out_o[SP] == cas_n_i));

    p_stby_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby_i && !keep_out_i && !hw_stby_i && mode_i != 2'd3 && dram_en_i) |->
            !pad_oe_o[SP]);

    p_stby_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby_i && keep_out_i && !hw_stby_i && mode_i != 2'd3 && dram_en_i &&
         $past(sw_stby_i) && $past(rst_n) && $stable(mode_i) && $stable(dram_en_i)) |->
            (pad_oe_o[SP] && $stable(pad_out_o[SP])));

endmodule

bind gpio_mode_port gpio_mode_port_chk u_chk (.*);

// File: tb/tb_gpio_mode_port.sv
module tb_gpio_mode_port;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n, hw_stby_i, man_rst_i, sw_stby_i, keep_out_i;
    logic [1:0] mode_i;
    logic       dram_en_i, wr_i, addr_i, cas_n_i;
    logic [7:0] wdata_i, rdata_o;
    logic [3:0] cs_n_i;
    logic [4:0] pad_in_i, pad_out_o, pad_oe_o;

    logic [4:0] m_dir, m_dat, m_hold;
    int         n_chk = 0;
    int         n_fail = 0;

    gpio_mode_port dut (.*);

    always #(CLK_P/2) clk = ~clk;

    // Bench model of pin function selection.
    function automatic logic [4:0] f_sel();
        logic [4:0] s;
        s[3:0] = (mode_i != 2'd3) ? m_dir[3:0] : 4'h0;
        s[4]   = (mode_i != 2'd3) && dram_en_i;
        return s;
    endfunction

    function automatic logic [4:0] f_live_out();
        logic [4:0] s = f_sel();
        return (s & {cas_n_i, cs_n_i}) | (~s & m_dat);
    endfunction

    function automatic logic [4:0] f_oe();
        logic [4:0] s = f_sel();
        if (hw_stby_i) return 5'h00;
        if (sw_stby_i && !keep_out_i) return (s | m_dir) & ~s;
        return s | m_dir;
    endfunction

    function automatic logic [4:0] f_out();
        logic [4:0] s = f_sel();
        if (sw_stby_i) return (s & m_hold) | (~s & f_live_out());
        return f_live_out();
    endfunction

    function automatic logic [7:0] f_rd();
        if (!addr_i) return 8'hFF;
        return {3'b000, (m_dat & m_dir) | (pad_in_i & ~m_dir)};
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: advance the model at the edge, then compare all outputs.
    task automatic tick(input string tag);
        logic [4:0] lo;
        logic [4:0] eo;
        @(posedge clk);
        lo = f_live_out();
        if (!rst_n || hw_stby_i) begin
            m_dir = {(mode_i < 2'd2), 4'h0};
            m_dat = 5'h00;
        end else if (wr_i && !man_rst_i && !sw_stby_i) begin
            if (!addr_i) m_dir = wdata_i[4:0];
            else         m_dat = wdata_i[4:0];
        end
        if (!rst_n)          m_hold = 5'h1F;
        else if (!sw_stby_i) m_hold = lo;
        #(CLK_P/4);
        eo = f_oe();
        check(tag, "oe", {3'b0, pad_oe_o}, {3'b0, eo});
        check(tag, "out", {3'b0, pad_out_o & eo}, {3'b0, f_out() & eo});
        check(tag, "rdata", rdata_o, f_rd());
    endtask

    task automatic idle();
        rst_n = 1'b1; hw_stby_i = 1'b0; man_rst_i = 1'b0; sw_stby_i = 1'b0;
        wr_i = 1'b0; addr_i = 1'b1; wdata_i = 8'h00;
    endtask

    task automatic wr(input logic a, input logic [7:0] d, input string tag);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        tick(tag);
        wr_i = 1'b0; addr_i = 1'b1;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; hw_stby_i = 1'b0; man_rst_i = 1'b0; sw_stby_i = 1'b0;
        keep_out_i = 1'b1; mode_i = 2'd3; dram_en_i = 1'b0; wr_i = 1'b0;
        addr_i = 1'b1; wdata_i = 8'h00; cs_n_i = 4'hF; cas_n_i = 1'b1; pad_in_i = 5'h00;
        m_dir = '0; m_dat = '0; m_hold = 5'h1F;

        // R1: reset value of the direction register in each mode, seen at the enables.
        for (int m = 0; m < 4; m++) begin
            mode_i = 2'(m); rst_n = 1'b0;
            tick("R1");
            rst_n = 1'b1;
            tick("R1");
            check("R1", "oe4", {7'b0, pad_oe_o[4]}, {7'b0, (m < 2)});
            check("R1", "data", rdata_o, 8'h00);
        end

        // R2: reserved write bits are dropped; data and direction loads.
        idle(); mode_i = 2'd3;
        wr(1'b0, 8'hE0, "R2");
        check("R2", "oe", {3'b0, pad_oe_o}, 8'h00);
        wr(1'b0, 8'h1F, "R2");
        wr(1'b1, 8'hF5, "R2");
        check("R2", "out", {3'b0, pad_out_o}, 8'h15);
        // R4: data read of output pins and of input pins.
        check("R4", "rd", rdata_o, 8'h15);
        wr(1'b0, 8'h03, "R4");
        pad_in_i = 5'h1A;
        tick("R4");
        check("R4", "rd_mix", rdata_o, 8'h19);
        // R3: direction read pattern.
        addr_i = 1'b0;
        tick("R3");
        check("R3", "rd_dir", rdata_o, 8'hFF);
        // R5: mode 7 plain I/O.
        check("R5", "oe", {3'b0, pad_oe_o}, 8'h03);

        // R8: manual reset keeps registers and blocks writes.
        man_rst_i = 1'b1;
        wr(1'b0, 8'h1F, "R8");
        wr(1'b1, 8'h00, "R8");
        check("R8", "oe", {3'b0, pad_oe_o}, 8'h03);
        check("R8", "out", {6'b0, pad_out_o[1:0]}, 8'h01);
        man_rst_i = 1'b0;

        // R9: software standby keeps registers; plain pins keep driving.
        sw_stby_i = 1'b1; keep_out_i = 1'b0;
        wr(1'b0, 8'h00, "R9");
        check("R9", "oe", {3'b0, pad_oe_o}, 8'h03);
        sw_stby_i = 1'b0;

        // R6: chip-select takeover in mode 6.
        mode_i = 2'd2; cs_n_i = 4'b1010;
        wr(1'b0, 8'h0C, "R6");
        check("R6", "oe", {3'b0, pad_oe_o}, 8'h0C);
        check("R6", "out", {4'b0, pad_out_o[3:2], 2'b0}, 8'h08);

        // R7: column strobe on pin 4 only in expanded modes.
        dram_en_i = 1'b1; cas_n_i = 1'b0;
        tick("R7");
        check("R7", "oe4", {7'b0, pad_oe_o[4]}, 8'h01);
        check("R7", "out4", {7'b0, pad_out_o[4]}, 8'h00);
        mode_i = 2'd3;
        tick("R7");
        check("R7", "oe4_m7", {7'b0, pad_oe_o[4]}, 8'h00);
        mode_i = 2'd2;

        // R10: hold of bus-control pins in software standby.
        cas_n_i = 1'b1; cs_n_i = 4'b0110;
        tick("R10");
        keep_out_i = 1'b1; sw_stby_i = 1'b1;
        tick("R10");
        cs_n_i = 4'b1001; cas_n_i = 1'b0;
        tick("R10");
        check("R10", "out", {3'b0, pad_out_o & 5'h1C}, 8'h14);
        check("R10", "oe", {3'b0, pad_oe_o & 5'h1C}, 8'h1C);

        // R11: release of bus-control pins in software standby.
        keep_out_i = 1'b0;
        tick("R11");
        check("R11", "oe", {3'b0, pad_oe_o}, 8'h00);
        sw_stby_i = 1'b0;

        // R12: hardware standby releases pins and reinitialises registers.
        hw_stby_i = 1'b1;
        tick("R12");
        check("R12", "oe", {3'b0, pad_oe_o}, 8'h00);
        hw_stby_i = 1'b0; dram_en_i = 1'b0;
        tick("R12");
        check("R12", "data", rdata_o, {3'b0, pad_in_i});

        // Random mix against the model.
        for (int k = 0; k < 3000; k++) begin
            rst_n      = ($urandom_range(63) != 0);
            hw_stby_i  = ($urandom_range(31) == 0);
            man_rst_i  = ($urandom_range(7) == 0);
            sw_stby_i  = ($urandom_range(5) == 0);
            keep_out_i = 1'($urandom_range(1));
            if ($urandom_range(49) == 0) mode_i = 2'($urandom_range(3));
            if ($urandom_range(19) == 0) dram_en_i = 1'($urandom_range(1));
            cs_n_i   = 4'($urandom_range(15));
            cas_n_i  = 1'($urandom_range(1));
            wr_i     = 1'($urandom_range(1));
            addr_i   = 1'($urandom_range(1));
            wdata_i  = 8'($urandom_range(255));
            pad_in_i = 5'($urandom_range(31));
            tick("rand");
        end

        summary();
        $finish;
    end

endmodule